// File: doc/BRIEF.md
# Prioritised Interrupt Routing Matrix

This block sits between a chip's peripheral interrupt sources and a single-hart core. Each of 62 level-sensitive sources is steered onto one of 31 numbered CPU interrupt lines by a small map register. Line 0 means "not routed". Software programs the routing through a byte-wide register bus. The same bus sets a per-line enable bitmap, a 4-bit priority per line and a global 4-bit threshold. A second register window holds four software-trigger bits. These raise sources 28 to 31 from code, ORed with the hardware inputs.

When a routed source rises, its line becomes pending. The line is handed to the core at once when three things hold: the line is enabled, its priority is strictly above the threshold, and the core's global interrupt enable is high. Delivery is a one-cycle `irq_valid` pulse carrying the line number, and it clears the pending bit. A line that cannot be delivered stays pending. When the core signals that its global enable has gone from 0 to 1, the arbiter moves from `ARB_WATCH` to `ARB_RESCAN` for one cycle. In that cycle it delivers the best eligible pending line: highest priority first, lowest line number on a tie. It then returns to `ARB_WATCH`. A further re-enable pulse seen during `ARB_RESCAN` keeps it in `ARB_RESCAN` for another cycle.

Top module: `irqm_matrix`

## Requirements
- R1: After reset every map register, the enable bitmap, the line-type word, all priorities, the threshold, the software triggers and the pending bitmap read as zero, and `irq_valid` is low.
- R2: Bus writes are one byte wide. A write merges into its 32-bit word and leaves the other bytes unchanged. The enable bitmap (word at 0x104, bit N = line N) and the line-type word (0x108, store-and-return only) both behave this way.
- R3: Source s has a 5-bit map field in byte 0 of the word at 4×s (0x000 to 0x0F4). It reads back masked to 5 bits. A source whose map field is 0 never sets a pending bit and never causes a delivery.
- R4: The pending bitmap reads at 0x10C, with bit N for line N. A rising routed source sets its line's bit. Bus writes to this word are ignored.
- R5: A source that rises on a line that is enabled, has priority strictly above the threshold, and meets `core_ie` = 1 gives `irq_valid` = 1 with that line on `irq_line` in the cycle after the rise. The pulse lasts one cycle and the pending bit is left clear. A priority equal to the threshold does not deliver.
- R6: A rise on a disabled line, or while `core_ie` = 0, leaves the line pending and gives no pulse.
- R7: When a source falls, its line's pending bit clears only if no other active source is mapped to that line.
- R8: A `core_ie_rise` pulse leads to exactly one delivery two clock edges later, picked from the pending, enabled lines above the threshold: highest priority wins, and the lowest line number breaks ties. The delivered line's pending bit clears and the others stay pending.
- R9: In the window at 0x800, bit 0 of the words at 0x828, 0x82C, 0x830 and 0x834 drives sources 28, 29, 30 and 31. These bits read back. A 1 asserts the source and a 0 releases it, exactly as a hardware level would.
- R10: At most one delivery happens per cycle. When several eligible sources rise together, the highest-priority line is delivered and the rest become pending.
- R11: Line L has its priority in the low 4 bits of byte 0 at 0x114 + 4×L. The threshold is the low 4 bits of byte 0 at 0x194. Both read back masked to 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_level | input | 62 | Peripheral interrupt levels, one per source |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 12 | Byte address; bit 11 selects the software-trigger window |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for `bus_addr` (combinational) |
| core_ie | input | 1 | Core global interrupt enable level |
| core_ie_rise | input | 1 | One-cycle pulse when the core's global enable goes 0 to 1 |
| irq_valid | output | 1 | One-cycle delivery pulse |
| irq_line | output | 5 | Line number being delivered |

## Verification
The assertions assume that `core_ie_rise` is only pulsed in cycles where `core_ie` is high or just became high. They also assume that source levels and bus writes change only between clock edges and stay stable across each edge. The bench drives every input on the falling edge and raises `core_ie` in the same cycle as each re-enable pulse. It changes routing only while the affected sources are low, so every edge on a line comes from a deliberate source transition.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
    localparam int ADDR_W      = 12;
    localparam int WORD_W      = ADDR_W - 3;
    localparam int SYS_WIN_BIT = ADDR_W - 1;

    // word indices (byte offset / 4) inside the matrix window
    localparam int IDX_EN      = 'h41;
    localparam int IDX_TYPE    = 'h42;
    localparam int IDX_PEND    = 'h43;
    localparam int IDX_PRIO0   = 'h45;
    localparam int IDX_THRESH  = 'h65;
    // word index of the first software trigger inside the system window
    localparam int IDX_SW0     = 'h0A;

    typedef enum logic [0:0] {
        ARB_WATCH  = 1'b0,
        ARB_RESCAN = 1'b1
    } arb_state_e;
endpackage

// File: rtl/irqm_regs.sv
module irqm_regs
    import irqm_pkg::*;
#(
    parameter int NUM_SRC  = 62,
    parameter int NUM_LINE = 32,
    parameter int PRIO_W   = 4,
    parameter int NUM_SW   = 4,
    localparam int LINE_W  = $clog2(NUM_LINE)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_wr,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [7:0]                         bus_wdata,
    output logic [7:0]                         bus_rdata,
    input  logic [NUM_LINE-1:0]                pend,
    output logic [NUM_SRC-1:0][LINE_W-1:0]     map_o,
    output logic [NUM_LINE-1:0]                en_o,
    output logic [NUM_LINE-1:0][PRIO_W-1:0]    prio_o,
    output logic [PRIO_W-1:0]                  thresh_o,
    output logic [NUM_SW-1:0]                  sw_o
);
    logic [NUM_SRC-1:0][LINE_W-1:0]  map_q;
    logic [NUM_LINE-1:0]             en_q;
    logic [31:0]                     type_q;
    logic [NUM_LINE-1:0][PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0]               thresh_q;
    logic [NUM_SW-1:0]               sw_q;

    logic              win_sys;
    logic [WORD_W-1:0] widx;
    logic [1:0]        bsel;
    logic              byte0;
    logic [31:0]       en_merged;
    logic [31:0]       type_merged;
    logic [31:0]       rword;

    assign win_sys = bus_addr[SYS_WIN_BIT];
    assign widx    = bus_addr[ADDR_W-2:2];
    assign bsel    = bus_addr[1:0];
    assign byte0   = (bsel == 2'd0);

    function automatic logic [31:0] put_byte(input logic [31:0] w,
                                             input logic [1:0]  b,
                                             input logic [7:0]  d);
        logic [31:0] r;
        r = w;
        r[{b, 3'b000} +: 8] = d;
        return r;
    endfunction

    assign en_merged   = put_byte(32'(en_q), bsel, bus_wdata);
    assign type_merged = put_byte(type_q, bsel, bus_wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q    <= '0;
            en_q     <= '0;
            type_q   <= '0;
            prio_q   <= '0;
            thresh_q <= '0;
            sw_q     <= '0;
        end else if (bus_wr) begin
            if (!win_sys) begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (byte0 && widx == WORD_W'(s)) map_q[s] <= bus_wdata[LINE_W-1:0];
                end
                if (widx == WORD_W'(IDX_EN))   en_q   <= en_merged[NUM_LINE-1:0];
                if (widx == WORD_W'(IDX_TYPE)) type_q <= type_merged;
                for (int l = 0; l < NUM_LINE; l++) begin
                    if (byte0 && widx == WORD_W'(IDX_PRIO0 + l)) prio_q[l] <= bus_wdata[PRIO_W-1:0];
                end
                if (byte0 && widx == WORD_W'(IDX_THRESH)) thresh_q <= bus_wdata[PRIO_W-1:0];
            end else begin
                for (int k = 0; k < NUM_SW; k++) begin
                    if (byte0 && widx == WORD_W'(IDX_SW0 + k)) sw_q[k] <= bus_wdata[0];
                end
            end
        end
    end

    always_comb begin
        rword = '0;
        if (!win_sys) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (widx == WORD_W'(s)) rword = 32'(map_q[s]);
            end
            if (widx == WORD_W'(IDX_EN))   rword = 32'(en_q);
            if (widx == WORD_W'(IDX_TYPE)) rword = type_q;
            if (widx == WORD_W'(IDX_PEND)) rword = 32'(pend);
            for (int l = 0; l < NUM_LINE; l++) begin
                if (widx == WORD_W'(IDX_PRIO0 + l)) rword = 32'(prio_q[l]);
            end
            if (widx == WORD_W'(IDX_THRESH)) rword = 32'(thresh_q);
        end else begin
            for (int k = 0; k < NUM_SW; k++) begin
                if (widx == WORD_W'(IDX_SW0 + k)) rword = 32'(sw_q[k]);
            end
        end
    end

    assign bus_rdata = rword[{bsel, 3'b000} +: 8];
    assign map_o     = map_q;
    assign en_o      = en_q;
    assign prio_o    = prio_q;
    assign thresh_o  = thresh_q;
    assign sw_o      = sw_q;

    AST_THRESH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(IDX_THRESH * 4)) |=> (thresh_o == $past(bus_wdata[PRIO_W-1:0]))); // R11
endmodule

// File: rtl/irqm_route.sv
module irqm_route #(
    parameter int NUM_SRC  = 62,
    parameter int NUM_LINE = 32,
    localparam int LINE_W  = $clog2(NUM_LINE)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             src_act,
    input  logic [NUM_SRC-1:0][LINE_W-1:0] map,
    output logic [NUM_LINE-1:0]            rise_line,
    output logic [NUM_LINE-1:0]            fall_line,
    output logic [NUM_LINE-1:0]            act_line
);
    logic [NUM_SRC-1:0] src_prev_q;
    logic [NUM_SRC-1:0] rise_src;
    logic [NUM_SRC-1:0] fall_src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_prev_q <= '0;
        else        src_prev_q <= src_act;
    end

    assign rise_src = src_act & ~src_prev_q;
    assign fall_src = ~src_act & src_prev_q;

    for (genvar L = 0; L < NUM_LINE; L++) begin : g_line
        if (L == 0) begin : g_unrouted
            assign rise_line[L] = 1'b0;
            assign fall_line[L] = 1'b0;
            assign act_line[L]  = 1'b0;
        end else begin : g_routed
            logic r, f, a;
            always_comb begin
                r = 1'b0;
                f = 1'b0;
                a = 1'b0;
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (map[s] == LINE_W'(L)) begin
                        r = r | rise_src[s];
                        f = f | fall_src[s];
                        a = a | src_act[s];
                    end
                end
            end
            assign rise_line[L] = r;
            assign fall_line[L] = f;
            assign act_line[L]  = a;
        end
    end

    AST_RISE_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_line & ~act_line) == '0)); // R4
endmodule

// File: rtl/irqm_pick.sv
module irqm_pick #(
    parameter int NUM_LINE = 32,
    parameter int PRIO_W   = 4,
    localparam int LINE_W  = $clog2(NUM_LINE)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_LINE-1:0]             cand,
    input  logic [NUM_LINE-1:0][PRIO_W-1:0] prio,
    output logic                            found,
    output logic [LINE_W-1:0]               sel
);
    logic [PRIO_W-1:0] best;

    // strict greater-than keeps the lowest-numbered line on equal priority
    always_comb begin
        found = 1'b0;
        sel   = '0;
        best  = '0;
        for (int l = 1; l < NUM_LINE; l++) begin
            if (cand[l] && (!found || prio[l] > best)) begin
                found = 1'b1;
                sel   = LINE_W'(l);
                best  = prio[l];
            end
        end
    end

    AST_PICK_IS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> cand[sel]); // R10
    AST_PICK_NONE_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cand[NUM_LINE-1:1] != '0) |-> found); // R8
endmodule

// File: rtl/irqm_matrix.sv
module irqm_matrix
    import irqm_pkg::*;
#(
    parameter int NUM_SRC  = 62,
    parameter int NUM_LINE = 32,
    parameter int PRIO_W   = 4,
    parameter int NUM_SW   = 4,
    parameter int SW_SRC0  = 28,
    localparam int LINE_W  = $clog2(NUM_LINE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_level,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic                core_ie,
    input  logic                core_ie_rise,
    output logic                irq_valid,
    output logic [LINE_W-1:0]   irq_line
);
    logic [NUM_SRC-1:0][LINE_W-1:0]  map_v;
    logic [NUM_LINE-1:0]             en_v;
    logic [NUM_LINE-1:0][PRIO_W-1:0] prio_v;
    logic [PRIO_W-1:0]               thresh_v;
    logic [NUM_SW-1:0]               sw_v;
    logic [NUM_SRC-1:0]              src_act;
    logic [NUM_LINE-1:0]             rise_line, fall_line, act_line;
    logic [NUM_LINE-1:0]             elig, cand, deliver_mask;
    logic [NUM_LINE-1:0]             pend_q, pend_d;
    logic                            pick_found;
    logic [LINE_W-1:0]               pick_sel;
    arb_state_e                      state_q, state_d;
    logic                            irq_valid_q;
    logic [LINE_W-1:0]               irq_line_q;

    irqm_regs #(.NUM_SRC(NUM_SRC), .NUM_LINE(NUM_LINE), .PRIO_W(PRIO_W), .NUM_SW(NUM_SW)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend(pend_q),
        .map_o(map_v), .en_o(en_v), .prio_o(prio_v), .thresh_o(thresh_v), .sw_o(sw_v)
    );

    always_comb begin
        src_act = src_level;
        for (int k = 0; k < NUM_SW; k++) begin
            src_act[SW_SRC0 + k] = src_level[SW_SRC0 + k] | sw_v[k];
        end
    end

    irqm_route #(.NUM_SRC(NUM_SRC), .NUM_LINE(NUM_LINE)) route_i (
        .clk(clk), .rst_n(rst_n), .src_act(src_act), .map(map_v),
        .rise_line(rise_line), .fall_line(fall_line), .act_line(act_line)
    );

    always_comb begin
        for (int l = 0; l < NUM_LINE; l++) begin
            elig[l] = (l != 0) && en_v[l] && (prio_v[l] > thresh_v) && core_ie;
        end
        cand = elig & (rise_line | ((state_q == ARB_RESCAN) ? pend_q : '0));
    end

    irqm_pick #(.NUM_LINE(NUM_LINE), .PRIO_W(PRIO_W)) pick_i (
        .clk(clk), .rst_n(rst_n), .cand(cand), .prio(prio_v),
        .found(pick_found), .sel(pick_sel)
    );

    assign deliver_mask = pick_found ? (NUM_LINE'(1) << pick_sel) : '0;
    assign pend_d = (pend_q | rise_line) & ~(fall_line & ~act_line) & ~deliver_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_WATCH;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_WATCH:  state_d = core_ie_rise ? ARB_RESCAN : ARB_WATCH;
            ARB_RESCAN: state_d = core_ie_rise ? ARB_RESCAN : ARB_WATCH;
            default:    state_d = ARB_WATCH;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_valid_q <= 1'b0;
            irq_line_q  <= '0;
        end else begin
            irq_valid_q <= pick_found;
            irq_line_q  <= pick_found ? pick_sel : '0;
        end
    end

    assign irq_valid = irq_valid_q;
    assign irq_line  = irq_line_q;

    AST_LINE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_line != '0)); // R3
    AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        pick_found |-> (en_v[pick_sel] && (prio_v[pick_sel] > thresh_v) && core_ie)); // R5
    AST_DELIVERED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !pend_q[irq_line]); // R5
    AST_RESCAN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_RESCAN) |-> $past(core_ie_rise)); // R8

    for (genvar L = 1; L < NUM_LINE; L++) begin : g_pchk
        AST_PEND_KEPT_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[L] && !pend_d[L]) |-> (!act_line[L] || (pick_found && pick_sel == LINE_W'(L)))); // R7
    end
endmodule

// File: tb/irqm_matrix_tb.sv
`timescale 1ns/1ps
module irqm_matrix_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [61:0] src_level = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        core_ie = 1'b0;
    logic        core_ie_rise = 1'b0;
    logic        irq_valid;
    logic [4:0]  irq_line;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    irqm_matrix dut_i (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_ie(core_ie), .core_ie_rise(core_ie_rise),
        .irq_valid(irq_valid), .irq_line(irq_line)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_rd(input logic [11:0] a, input logic [7:0] e, input string tag);
        logic [7:0] d;
        rd(a, d);
        check(d == e, tag, d, e);
    endtask

    task automatic expect_irq(input logic v, input logic [4:0] ln, input string tag);
        check(irq_valid == v && (!v || irq_line == ln), tag, {irq_valid, irq_line}, {v, ln});
    endtask

    task automatic set_src(input int s, input logic v);
        @(negedge clk);
        src_level[s] = v;
    endtask

    task automatic t_reset();
        expect_irq(1'b0, 5'd0, "R1 no delivery after reset");
        expect_rd(12'h10C, 8'h00, "R1 pending zero");
        expect_rd(12'h104, 8'h00, "R1 enable zero");
        expect_rd(12'h00C, 8'h00, "R1 map zero");
        expect_rd(12'h120, 8'h00, "R1 priority zero");
        expect_rd(12'h194, 8'h00, "R1 threshold zero");
        expect_rd(12'h82C, 8'h00, "R1 sw trigger zero");
    endtask

    task automatic t_bytes();
        wr(12'h106, 8'hA5);
        expect_rd(12'h106, 8'hA5, "R2 enable byte2 written");
        expect_rd(12'h104, 8'h00, "R2 enable byte0 untouched");
        wr(12'h106, 8'h00);
        wr(12'h108, 8'h12);
        wr(12'h10B, 8'h9C);
        expect_rd(12'h108, 8'h12, "R2 type byte0");
        expect_rd(12'h10B, 8'h9C, "R2 type byte3");
        expect_rd(12'h109, 8'h00, "R2 type byte1 untouched");
        wr(12'h10C, 8'hFF);
        expect_rd(12'h10C, 8'h00, "R4 pending ignores writes");
    endtask

    task automatic t_immediate();
        // src3 -> line5, line5 enabled, prio6, thresh2
        wr(12'h00C, 8'h05);
        wr(12'h104, 8'h20);
        wr(12'h128, 8'h06);
        wr(12'h194, 8'h02);
        core_ie = 1'b1;
        set_src(3, 1'b1);
        @(negedge clk);
        expect_irq(1'b1, 5'd5, "R5 immediate delivery");
        @(negedge clk);
        expect_irq(1'b0, 5'd0, "R5 single-cycle pulse");
        expect_rd(12'h10C, 8'h00, "R5 delivered line not pending");
        set_src(3, 1'b0);
    endtask

    task automatic t_thresh_equal();
        wr(12'h194, 8'h06);
        set_src(3, 1'b1);
        @(negedge clk);
        expect_irq(1'b0, 5'd0, "R5 prio equal to threshold not delivered");
        expect_rd(12'h10C, 8'h20, "R4 pending bit5 set");
        set_src(3, 1'b0);
        expect_rd(12'h10C, 8'h00, "R7 sole source fall clears pending");
    endtask

    task automatic t_shared();
        wr(12'h01C, 8'h05);                 // src7 -> line5
        set_src(3, 1'b1);
        set_src(7, 1'b1);
        set_src(3, 1'b0);
        expect_rd(12'h10C, 8'h20, "R7 pending kept while src7 active");
        set_src(7, 1'b0);
        expect_rd(12'h10C, 8'h00, "R7 last source fall clears pending");
    endtask

    task automatic t_unmapped();
        set_src(9, 1'b1);
        @(negedge clk);
        expect_irq(1'b0, 5'd0, "R3 unmapped source no delivery");
        expect_rd(12'h10C, 8'h00, "R3 unmapped source no pending");
        expect_rd(12'h10D, 8'h00, "R3 unmapped source no pending hi");
        set_src(9, 1'b0);
    endtask

    task automatic t_rescan();
        wr(12'h194, 8'h02);
        wr(12'h030, 8'h09);                 // src12 -> line9
        wr(12'h138, 8'h06);                 // prio9 = 6
        wr(12'h038, 8'h07);                 // src14 -> line7
        wr(12'h130, 8'h0F);                 // prio7 = 15, line7 disabled
        wr(12'h105, 8'h02);                 // enable line9
        core_ie = 1'b0;
        set_src(3, 1'b1);
        set_src(12, 1'b1);
        set_src(14, 1'b1);
        @(negedge clk);
        expect_irq(1'b0, 5'd0, "R6 no delivery while core disabled");
        expect_rd(12'h10C, 8'hA0, "R6 lines 5 and 7 pending");
        expect_rd(12'h10D, 8'h02, "R6 line 9 pending");
        @(negedge clk);
        core_ie = 1'b1; core_ie_rise = 1'b1;
        @(negedge clk);
        core_ie_rise = 1'b0;
        expect_irq(1'b0, 5'd0, "R8 no delivery on pulse edge");
        @(negedge clk);
        expect_irq(1'b1, 5'd5, "R8 rescan tie goes to lowest line");
        @(negedge clk);
        expect_irq(1'b0, 5'd0, "R8 one delivery per rescan");
        expect_rd(12'h10C, 8'h80, "R8 line7 stays pending (disabled)");
        expect_rd(12'h10D, 8'h02, "R8 line9 stays pending");
        @(negedge clk);
        core_ie_rise = 1'b1;
        @(negedge clk);
        core_ie_rise = 1'b0;
        @(negedge clk);
        expect_irq(1'b1, 5'd9, "R8 second rescan delivers line9");
        set_src(3, 1'b0);
        set_src(12, 1'b0);
        set_src(14, 1'b0);
        expect_rd(12'h10C, 8'h00, "R7 all released lo");
        expect_rd(12'h10D, 8'h00, "R7 all released hi");
    endtask

    task automatic t_simultaneous();
        wr(12'h138, 8'h0A);                 // prio9 = 10
        @(negedge clk);
        src_level[3] = 1'b1; src_level[12] = 1'b1;
        @(negedge clk);
        expect_irq(1'b1, 5'd9, "R10 higher priority wins");
        @(negedge clk);
        expect_irq(1'b0, 5'd0, "R10 only one delivery");
        expect_rd(12'h10C, 8'h20, "R10 loser stays pending");
        @(negedge clk);
        src_level[3] = 1'b0; src_level[12] = 1'b0;
        expect_rd(12'h10C, 8'h00, "R7 released after simultaneous");
    endtask

    task automatic t_swtrig();
        wr(12'h074, 8'h05);                 // src29 -> line5
        wr(12'h82C, 8'h01);
        @(negedge clk);
        expect_irq(1'b1, 5'd5, "R9 sw trigger delivers line5");
        expect_rd(12'h82C, 8'h01, "R9 sw trigger reads back");
        wr(12'h82C, 8'h00);
        wr(12'h194, 8'h06);
        wr(12'h82C, 8'h01);
        expect_rd(12'h10C, 8'h20, "R9 sw trigger sets pending");
        wr(12'h82C, 8'h00);
        expect_rd(12'h10C, 8'h00, "R9 sw release clears pending");
    endtask

    task automatic t_widths();
        expect_rd(12'h138, 8'h0A, "R11 priority readback");
        wr(12'h194, 8'h3F);
        expect_rd(12'h194, 8'h0F, "R11 threshold masked to 4 bits");
        wr(12'h13C, 8'hF7);
        expect_rd(12'h13C, 8'h07, "R11 priority masked to 4 bits");
        wr(12'h00C, 8'hFF);
        expect_rd(12'h00C, 8'h1F, "R3 map masked to 5 bits");
        wr(12'h00D, 8'h44);
        expect_rd(12'h00D, 8'h00, "R3 map upper byte not stored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bytes();
        t_immediate();
        t_thresh_equal();
        t_shared();
        t_unmapped();
        t_rescan();
        t_simultaneous();
        t_swtrig();
        t_widths();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule